// File: doc/BRIEF.md
# Prefetch Queue with Branch Folding

This block is a small instruction buffer that sits between an instruction fetch engine and the decode/dispatch stage. Fetch and dispatch can therefore run at different rates. The fetch engine reads up to two consecutive words per cycle from a zero-latency instruction memory port, starting at the address the block presents. The dispatch side receives at most one instruction per cycle from the oldest queue entry. Because fetch can outpace dispatch, the queue tends to stay full. When fetch stalls, for example on a cache miss, the buffered words keep dispatch busy until the queue drains.

The block decodes unconditional branches in the two oldest entries and computes each branch target from the branch address and its offset field. The best case is a non-branch instruction at the head with a branch directly behind it. The head dispatches, the branch is absorbed without using a dispatch slot, every younger entry is discarded, and fetch is steered to the target in that same cycle. The target instruction then dispatches on the very next cycle. When a branch reaches the head with nothing older queued, it has to be dispatched itself. It then uses one dispatch slot, which is the one-cycle bubble of the unfolded case.

Top module: `fold_iqueue`

## Requirements
- R1: After reset, `disp_valid` is 0, `fetch_pc` equals the parameter RESET_PC (default 0) and `fetch_rdy` is 1.
- R2: Fetched words are accepted in address order: `fetch_word0` belongs to `fetch_pc` and `fetch_word1` to `fetch_pc`+1. Whenever the queue is non-empty, one instruction dispatches per cycle from its oldest entry, in program order.
- R3: An instruction is an unconditional branch when bits [31:26] equal 6'b111111. Its target is its own address plus bits [11:0] taken as a signed word offset. All other instructions are sequential.
- R4: When the oldest entry is not a branch and the second-oldest is, the oldest entry dispatches, the branch is never dispatched, and `fetch_pc` shows the target in that same cycle. The target then dispatches in the next cycle with no empty dispatch cycle.
- R5: A branch in the oldest entry is dispatched with `disp_branch` = 1, and `fetch_pc` shows its target in that cycle.
- R6: On every redirect, all entries younger than the branch are discarded, so no wrong-path instruction is ever dispatched.
- R7: `fetch_rdy` is 0 when fewer than two entries are free and no redirect is under way. Words offered while it is 0 are ignored, and `fetch_pc` does not advance.
- R8: While `fetch_cnt` is 0, dispatch continues from the buffered words until the queue is empty. After that, `disp_valid` is 0.
- R9: `fetch_cnt` values 0, 1 and 2 (3 is taken as 2) accept that many words when ready, and `fetch_pc` advances by the number accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | output | 16 | Word address the fetch engine reads this cycle |
| fetch_rdy | output | 1 | Queue can take up to two words this cycle |
| fetch_cnt | input | 2 | Number of words offered this cycle |
| fetch_word0 | input | 32 | Word read at `fetch_pc` |
| fetch_word1 | input | 32 | Word read at `fetch_pc`+1 |
| disp_valid | output | 1 | An instruction is dispatched this cycle |
| disp_instr | output | 32 | Dispatched instruction word |
| disp_pc | output | 16 | Address of the dispatched instruction |
| disp_branch | output | 1 | Dispatched instruction is an unfolded branch |

## Verification
A fold dispatches the oldest entry, absorbs the branch behind it, flushes the rest and accepts the first two target words, all in one cycle. A single off-by-one in the pointers or count therefore shows up as a lost, repeated or wrong-path instruction. The bench provokes this by fetching two words per cycle into a program whose branches arrive second in the queue. It checks cycle by cycle that the target dispatches right after the folded branch's predecessor, with `fetch_pc` equal to the target in the fold cycle. A pseudo-random fetch stall pattern then lets a program-order reference model catch any dispatch outside the correct path. Those stalls also make folds land at full-queue and empty-queue boundaries.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
    localparam int IW   = 32;          // instruction word width
    localparam int AW   = 16;          // word address width
    localparam int OFFW = 12;          // branch offset field width
    localparam int OPW  = 6;           // opcode field width
    localparam logic [OPW-1:0] BR_OP = '1;

    typedef struct packed {
        logic [IW-1:0] instr;
        logic [AW-1:0] pc;
    } fiq_entry_t;

    function automatic logic is_branch(input logic [IW-1:0] w);
        return w[IW-1 -: OPW] == BR_OP;
    endfunction

    function automatic logic [AW-1:0] br_target(input fiq_entry_t e);
        logic [AW-1:0] off;
        off = {{(AW-OFFW){e.instr[OFFW-1]}}, e.instr[OFFW-1:0]};
        return e.pc + off;
    endfunction
endpackage

// File: rtl/fiq_buf.sv
module fiq_buf
    import fiq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      pop_n,
    input  logic            flush,
    input  logic [1:0]      push_n,
    input  fiq_entry_t      push_w0,
    input  fiq_entry_t      push_w1,
    output fiq_entry_t      head0,
    output fiq_entry_t      head1,
    output logic [CW-1:0]   count
);
    fiq_entry_t      slots [DEPTH];
    logic [PW-1:0]   hd_q, hd_nx, wr0, wr1;
    logic [CW-1:0]   cnt_q, base;
    logic            we0, we1;

    always_comb begin
        hd_nx = hd_q + PW'(pop_n);
        base  = flush ? '0 : cnt_q - CW'(pop_n);
        wr0   = hd_nx + base[PW-1:0];
        wr1   = wr0 + PW'(1);
        we0   = push_n != 2'd0;
        we1   = push_n == 2'd2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_q  <= '0;
            cnt_q <= '0;
        end else begin
            hd_q  <= hd_nx;
            cnt_q <= base + CW'(push_n);
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we0 && wr0 == PW'(gi))
                slots[gi] <= push_w0;
            else if (we1 && wr1 == PW'(gi))
                slots[gi] <= push_w1;
        end
    end

    assign head0 = slots[hd_q];
    assign head1 = slots[hd_q + PW'(1)];
    assign count = cnt_q;
endmodule

// File: rtl/fiq_sel.sv
module fiq_sel
    import fiq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  fiq_entry_t      head0,
    input  fiq_entry_t      head1,
    input  logic [CW-1:0]   count,
    output logic            disp_valid,
    output fiq_entry_t      disp_entry,
    output logic            disp_branch,
    output logic [1:0]      pop_n,
    output logic            redir,
    output logic [AW-1:0]   target
);
    always_comb begin
        disp_valid  = 1'b0;
        disp_entry  = head0;
        disp_branch = 1'b0;
        pop_n       = 2'd0;
        redir       = 1'b0;
        target      = br_target(head0);
        if (count != '0) begin
            disp_valid = 1'b1;
            pop_n      = 2'd1;
            if (is_branch(head0.instr)) begin
                // branch is oldest: it takes the dispatch slot itself
                disp_branch = 1'b1;
                redir       = 1'b1;
            end else if (count >= CW'(2) && is_branch(head1.instr)) begin
                // fold: branch absorbed behind the dispatching instruction
                pop_n  = 2'd2;
                redir  = 1'b1;
                target = br_target(head1);
            end
        end
    end
endmodule

// File: rtl/fold_iqueue.sv
module fold_iqueue
    import fiq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic            clk,
    input  logic            rst,
    output logic [15:0]     fetch_pc,
    output logic            fetch_rdy,
    input  logic [1:0]      fetch_cnt,
    input  logic [31:0]     fetch_word0,
    input  logic [31:0]     fetch_word1,
    output logic            disp_valid,
    output logic [31:0]     disp_instr,
    output logic [15:0]     disp_pc,
    output logic            disp_branch
);
    localparam int CW = $clog2(DEPTH + 1);

    fiq_entry_t      head0, head1, disp_entry, w0, w1;
    logic [CW-1:0]   count;
    logic [1:0]      pop_n, push_n;
    logic            redir;
    logic [AW-1:0]   target, pc_q;

    fiq_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .pop_n(pop_n), .flush(redir),
        .push_n(push_n), .push_w0(w0), .push_w1(w1),
        .head0(head0), .head1(head1), .count(count)
    );

    fiq_sel #(.DEPTH(DEPTH)) u_sel (
        .head0(head0), .head1(head1), .count(count),
        .disp_valid(disp_valid), .disp_entry(disp_entry),
        .disp_branch(disp_branch), .pop_n(pop_n),
        .redir(redir), .target(target)
    );

    always_comb begin
        fetch_pc  = redir ? target : pc_q;
        fetch_rdy = redir || (count <= CW'(DEPTH - 2));
        if (!fetch_rdy)
            push_n = 2'd0;
        else if (fetch_cnt == 2'd3)
            push_n = 2'd2;
        else
            push_n = fetch_cnt;
        w0 = '{instr: fetch_word0, pc: fetch_pc};
        w1 = '{instr: fetch_word1, pc: fetch_pc + AW'(1)};
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else
            pc_q <= fetch_pc + AW'(push_n);
    end

    assign disp_instr = disp_entry.instr;
    assign disp_pc    = disp_entry.pc;
endmodule

// File: rtl/fiq_chk.sv
module fiq_chk
    import fiq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   fetch_pc,
    input logic            fetch_rdy,
    input logic            disp_valid,
    input logic [IW-1:0]   disp_instr,
    input logic [AW-1:0]   disp_pc,
    input logic            disp_branch,
    input logic            redir
);
    // R2: without a redirect the next dispatch is the next address
    a_r2_seq_order: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !redir) |=> (!disp_valid || disp_pc == $past(disp_pc) + AW'(1)));

    // R4, R6: after a redirect the next dispatch comes from the target
    a_r4_target_next: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && redir) |=> (!disp_valid || disp_pc == $past(fetch_pc)));

    // R5: a dispatched branch steers fetch to its own target
    a_r5_branch_steer: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_branch) |-> fetch_pc == br_target('{instr: disp_instr, pc: disp_pc}));

    // R7: no acceptance while not ready, so the fetch address holds
    a_r7_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        !fetch_rdy |=> (redir || fetch_pc == $past(fetch_pc)));
endmodule

bind fold_iqueue fiq_chk u_chk (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_rdy(fetch_rdy),
    .disp_valid(disp_valid), .disp_instr(disp_instr), .disp_pc(disp_pc),
    .disp_branch(disp_branch), .redir(redir)
);

// File: tb/fold_iqueue_tb.sv
module fold_iqueue_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] fetch_pc;
    logic        fetch_rdy;
    logic [1:0]  fetch_cnt = 2'd0;
    logic [31:0] fetch_word0, fetch_word1;
    logic        disp_valid, disp_branch;
    logic [31:0] disp_instr;
    logic [15:0] disp_pc;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [15:0] exp_pc = 16'd0;

    always #5 clk = ~clk;

    fold_iqueue u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_rdy(fetch_rdy),
        .fetch_cnt(fetch_cnt), .fetch_word0(fetch_word0), .fetch_word1(fetch_word1),
        .disp_valid(disp_valid), .disp_instr(disp_instr), .disp_pc(disp_pc),
        .disp_branch(disp_branch)
    );

    // program: branches at a few addresses (R3 encoding), the rest sequential
    function automatic bit br_at(input logic [15:0] a);
        return a == 16'd3 || a == 16'd22 || a == 16'd80 || a == 16'd81 || a == 16'd100;
    endfunction

    function automatic logic [15:0] dest(input logic [15:0] a);
        case (a)
            16'd3:   return 16'd20;
            16'd22:  return 16'd40;
            16'd80:  return 16'd81;
            16'd81:  return 16'd83;
            16'd100: return 16'd60;
            default: return a + 16'd1;
        endcase
    endfunction

    function automatic logic [31:0] prog(input logic [15:0] a);
        logic [15:0] d;
        d = dest(a) - a;
        if (br_at(a)) return {6'b111111, 14'd0, d[11:0]};
        return {6'b000000, 10'd0, a};
    endfunction

    assign fetch_word0 = prog(fetch_pc);
    assign fetch_word1 = prog(fetch_pc + 16'd1);

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // program-order reference: folded branches are skipped, nothing else
    task automatic observe();
        if (disp_valid) begin
            for (int k = 0; k < 4; k++)
                if (br_at(exp_pc) && disp_pc != exp_pc) exp_pc = dest(exp_pc);
            check(disp_pc == exp_pc, "R6 path/order", disp_pc, exp_pc);
            check(disp_branch == br_at(exp_pc), "R5 branch flag", disp_branch, br_at(exp_pc));
            exp_pc = dest(exp_pc);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fetch_cnt = 2'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_pc = 16'd0;
    endtask

    // {rst, fcnt[1:0], ev, ebr, epc[15:0], efpc[15:0]}
    localparam int NV = 25;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 2'd0, 1'b0, 1'b0, 16'd0,  16'd0},
        {1'b0, 2'd2, 1'b0, 1'b0, 16'd0,  16'd0},   // R1
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd0,  16'd2},   // R2
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd1,  16'd4},
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd2,  16'd20},  // R4 fold of 3
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd20, 16'd22},  // R4 no bubble
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd21, 16'd40},  // R4 fold of 22
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd40, 16'd42},  // R6
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd41, 16'd44},
        {1'b0, 2'd0, 1'b1, 1'b0, 16'd42, 16'd46},  // R8 stall begins
        {1'b0, 2'd0, 1'b1, 1'b0, 16'd43, 16'd46},
        {1'b0, 2'd0, 1'b1, 1'b0, 16'd44, 16'd46},
        {1'b0, 2'd0, 1'b1, 1'b0, 16'd45, 16'd46},
        {1'b0, 2'd2, 1'b0, 1'b0, 16'd0,  16'd46},  // R8 drained
        {1'b0, 2'd2, 1'b1, 1'b0, 16'd46, 16'd48},
        {1'b1, 2'd0, 1'b0, 1'b0, 16'd0,  16'd0},
        {1'b0, 2'd1, 1'b0, 1'b0, 16'd0,  16'd0},   // R9 one word per cycle
        {1'b0, 2'd1, 1'b1, 1'b0, 16'd0,  16'd1},
        {1'b0, 2'd1, 1'b1, 1'b0, 16'd1,  16'd2},
        {1'b0, 2'd1, 1'b1, 1'b0, 16'd2,  16'd3},
        {1'b0, 2'd1, 1'b1, 1'b1, 16'd3,  16'd20},  // R5 lone branch
        {1'b0, 2'd1, 1'b1, 1'b0, 16'd20, 16'd21},
        {1'b0, 2'd1, 1'b1, 1'b0, 16'd21, 16'd22},
        {1'b0, 2'd1, 1'b1, 1'b1, 16'd22, 16'd40},  // R5
        {1'b0, 2'd1, 1'b1, 1'b0, 16'd40, 16'd41}
    };

    initial begin
        int rdy_low;
        int gaps;
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(disp_valid == 1'b0, "R1 disp_valid", disp_valid, 0);
        check(fetch_pc == 16'd0, "R1 fetch_pc", fetch_pc, 0);
        check(fetch_rdy == 1'b1, "R1 fetch_rdy", fetch_rdy, 1);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) begin
                do_reset();
            end else begin
                check(disp_valid == VEC[i][33], "R2/R8 disp_valid", disp_valid, VEC[i][33]);
                if (VEC[i][33]) begin
                    check(disp_pc == VEC[i][31:16], "R2/R4 disp_pc", disp_pc, VEC[i][31:16]);
                    check(disp_branch == VEC[i][32], "R5 disp_branch", disp_branch, VEC[i][32]);
                end
                check(fetch_pc == VEC[i][15:0], "R9/R4 fetch_pc", fetch_pc, VEC[i][15:0]);
                observe();
                fetch_cnt = VEC[i][35:34];
                @(negedge clk);
            end
        end

        // R7: continuous double fetch fills the queue; ready must drop
        do_reset();
        rdy_low = 0;
        gaps = 0;
        fetch_cnt = 2'd2;
        for (int c = 0; c < 40; c++) begin
            if (c >= 1 && !disp_valid) gaps++;
            if (!fetch_rdy) rdy_low++;
            observe();
            @(negedge clk);
        end
        check(rdy_low > 0, "R7 ready drops when full", rdy_low, 1);
        check(gaps == 0, "R4 no dispatch gaps at full rate", gaps, 0);

        // random fetch stalls over looping code with a backward branch
        do_reset();
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            observe();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fetch_cnt = lfsr[1:0];
            @(negedge clk);
        end
        check(exp_pc >= 16'd60 && exp_pc <= 16'd101, "R6 loop reached", exp_pc, 60);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule